// File: doc/BRIEF.md
# Five-Sample Optimal-Filter Amplitude and Phase Estimator

This block sits behind a digitizer that samples a shaped detector pulse. Each accepted window of five consecutive samples has a programmable pedestal subtracted from every sample. Two sets of fixed-point weights are then applied to the same window in parallel. The amplitude set acts like an integration and suppresses series noise. The timing set acts like a differentiation and suppresses pile-up; its sum estimates amplitude multiplied by the pulse's time offset. When the amplitude sum is positive, a bit-serial divider forms the ratio of the timing sum to the amplitude sum, which gives the phase of the pulse relative to the sampling grid.

A window opens with a start marker that arrives together with a valid sample. Cycles where the valid strobe is low are skipped, so the samples of a window may arrive with gaps between them. The two sums are reported one cycle after the fifth sample. The quotient follows after a fixed number of divider cycles. While the divider runs, the block raises `busy` and discards every incoming sample. The weights and the pedestal sit in registers written through a simple write port, so a different pulse shape can be loaded without rebuilding the block.

Top module: `ofe_estimator`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `amp_valid`, `time_valid`, `time_bad` and `busy` are low, and `amp_out`, `at_out` and `time_out` are zero.
- R2: `amp_out` equals the amplitude sum S = Σ (sample_i − pedestal)·a_i over the five window samples, with each a_i a signed Q1.15 weight. S is rounded as floor((S + 2^14) / 2^15), so a tie rounds upward, and then saturated to signed 16 bits. `amp_valid` pulses for one cycle, in the cycle after the clock edge that captures the fifth sample.
- R3: `at_out` carries the timing sum formed in the same way with the timing weights. It is rounded and saturated like `amp_out` and is presented in the same cycle as `amp_valid`.
- R4: After reset, amplitude weights for taps 0..4 are 5571, 11141, 13107, 10158, 9175, and timing weights are −24576, 15401, 24576, 2294, −6226 (all Q1.15). The pedestal resets to 0.
- R5: A write with `cfg_we` high at a clock edge updates one register. Addresses 0–4 hold amplitude taps 0–4, addresses 5–9 hold timing taps 0–4, and address 10 takes the pedestal from the low 12 bits of `cfg_wdata`. A write to any other address changes nothing. The new value applies to samples accepted at later edges.
- R6: A window opens only on a cycle with both `in_valid` and `in_start` high. Valid samples that arrive outside a window are ignored. Cycles inside a window where `in_valid` is low are skipped.
- R7: A start marker that arrives inside an open window discards the partial sums and opens a new window, with that sample as its first sample.
- R8: If the raw amplitude sum A is greater than zero, `time_out` = sign(T)·floor((2·|T|·256 + A) / (2·A)), where T is the raw timing sum. This is time in sample periods with 8 fractional bits, rounded half away from zero. `time_valid` pulses with `time_bad` low exactly 42 cycles after the `amp_valid` cycle.
- R9: If A is zero or negative, no division runs. `time_valid` and `time_bad` pulse in the same cycle as `amp_valid`, `time_out` is 0, and `busy` stays low.
- R10: `busy` is high for exactly the 42 cycles from the `amp_valid` cycle of a divided window up to the cycle before `time_valid`. Any sample presented while `busy` is high is dropped, including a start marker.
- R11: A quotient above 32767 gives `time_out` = 32767. A negative quotient whose magnitude exceeds 32768 gives −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_start | input | 1 | First sample of a window, qualified by `in_valid` |
| in_sample | input | 12 | Unsigned ADC sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address (0–4 amplitude, 5–9 timing, 10 pedestal) |
| cfg_wdata | input | 16 | Write data (Q1.15 weight, or pedestal in the low 12 bits) |
| busy | output | 1 | Divider running; incoming samples are dropped |
| amp_valid | output | 1 | Amplitude and timing sums valid |
| amp_out | output | 16 | Rounded amplitude sum, signed |
| at_out | output | 16 | Rounded amplitude-times-time sum, signed |
| time_valid | output | 1 | Time result or invalid flag present |
| time_bad | output | 1 | Amplitude was not positive; `time_out` is not meaningful |
| time_out | output | 16 | Time offset, signed, 8 fractional bits |

## Verification
Both sums are due in the cycle right after the edge that captures the fifth accepted sample. The quotient is due 42 cycles later, and `busy` is held for every cycle in between. A non-positive amplitude raises its invalid-time flag in the same cycle as the sums. The bench drives inputs on the falling edge. It then checks each result on the falling edge of exactly the cycle where it is due. During the divider wait it watches every cycle, to confirm that `busy` stays high and that no result arrives early. After a window fed while `busy` is high, it sends strays without a start marker and confirms that no window completes.

// File: rtl/ofe_pkg.sv
package ofe_pkg;
   typedef enum int {LANE_AMP = 0, LANE_TIME = 1} lane_e;
   localparam int LANES = 2;

   // Q1.15 weights, tap 0 in the least significant 16 bits
   localparam logic [79:0] AMP_Q15_DEF =
      {16'd9175, 16'd10158, 16'd13107, 16'd11141, 16'd5571};
   localparam logic [79:0] TIME_Q15_DEF =
      {16'd59310, 16'd2294, 16'd24576, 16'd15401, 16'd40960};
endpackage

// File: rtl/ofe_coef_bank.sv
module ofe_coef_bank #(
   parameter int TAPS     = 5,
   parameter int COEF_W   = 16,
   parameter int SAMPLE_W = 12,
   parameter int ADDR_W   = 4,
   parameter logic [TAPS*COEF_W-1:0] AMP_INIT  = '0,
   parameter logic [TAPS*COEF_W-1:0] TIME_INIT = '0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [COEF_W-1:0]        wdata,
   output logic [TAPS*COEF_W-1:0]   amp_flat,
   output logic [TAPS*COEF_W-1:0]   time_flat,
   output logic [SAMPLE_W-1:0]      ped
);
   localparam logic [ADDR_W-1:0] PED_ADDR = ADDR_W'(2*TAPS);

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic [COEF_W-1:0] amp_r, time_r;
      always_ff @(posedge clk) begin
         if (rst)
            amp_r <= AMP_INIT[t*COEF_W +: COEF_W];
         else if (we && addr == ADDR_W'(t))
            amp_r <= wdata;
      end
      always_ff @(posedge clk) begin
         if (rst)
            time_r <= TIME_INIT[t*COEF_W +: COEF_W];
         else if (we && addr == ADDR_W'(TAPS + t))
            time_r <= wdata;
      end
      assign amp_flat[t*COEF_W +: COEF_W]  = amp_r;
      assign time_flat[t*COEF_W +: COEF_W] = time_r;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ped <= '0;
      else if (we && addr == PED_ADDR)
         ped <= wdata[SAMPLE_W-1:0];
   end
endmodule

// File: rtl/ofe_mac.sv
module ofe_mac #(
   parameter int TAPS     = 5,
   parameter int SAMPLE_W = 12,
   parameter int COEF_W   = 16,
   parameter int ACC_W    = 32,
   parameter int OUT_W    = 16,
   parameter int IDX_W    = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         take,
   input  logic                         first,
   input  logic [IDX_W-1:0]             idx,
   input  logic [SAMPLE_W-1:0]          sample,
   input  logic [SAMPLE_W-1:0]          ped,
   input  logic [TAPS*COEF_W-1:0]       coefs,
   output logic signed [ACC_W-1:0]      sum_nxt,
   output logic signed [OUT_W-1:0]      rnd
);
   localparam int PROD_W = SAMPLE_W + 1 + COEF_W;
   localparam int FRAC   = COEF_W - 1;
   localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) <<< (FRAC - 1);
   localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'((2**(OUT_W-1)) - 1);
   localparam logic signed [ACC_W:0] MINV = -((ACC_W+1)'(2**(OUT_W-1)));

   logic signed [ACC_W-1:0]  acc_r;
   logic signed [COEF_W-1:0] coef;
   logic signed [SAMPLE_W:0] diff;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W:0]    biased, scaled;

   assign coef    = coefs[idx*COEF_W +: COEF_W];
   assign diff    = $signed({1'b0, sample}) - $signed({1'b0, ped});
   assign prod    = diff * coef;
   assign sum_nxt = (first ? '0 : acc_r) +
                    {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

   // round half up on the full-precision sum, then clamp
   assign biased = {sum_nxt[ACC_W-1], sum_nxt} + HALF;
   assign scaled = biased >>> FRAC;

   always_comb begin
      if (scaled > MAXV)      rnd = MAXV[OUT_W-1:0];
      else if (scaled < MINV) rnd = MINV[OUT_W-1:0];
      else                    rnd = scaled[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)       acc_r <= '0;
      else if (take) acc_r <= sum_nxt;
   end
endmodule

// File: rtl/ofe_divider.sv
module ofe_divider #(
   parameter int ACC_W = 32,
   parameter int TF    = 8,
   parameter int OUT_W = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic signed [ACC_W-1:0]  num,
   input  logic signed [ACC_W-1:0]  den,
   output logic                     busy,
   output logic                     fin,
   output logic signed [OUT_W-1:0]  quo
);
   localparam int DIVD_W = ACC_W + TF + 2;
   localparam int REM_W  = ACC_W + 1;
   localparam int CNT_W  = $clog2(DIVD_W + 1);
   localparam logic [DIVD_W-1:0] POS_LIM = DIVD_W'((2**(OUT_W-1)) - 1);
   localparam logic [DIVD_W-1:0] NEG_LIM = DIVD_W'(2**(OUT_W-1));

   logic [DIVD_W-1:0] quo_r, quo_n, dvd_init;
   logic [REM_W-1:0]  rem_r, rem_n, dvs_r, dvs_init, sh;
   logic [CNT_W-1:0]  cnt_r;
   logic              busy_r, neg_r, ge;
   logic signed [ACC_W:0] num_x;
   logic [ACC_W:0]        mag;

   assign num_x    = {num[ACC_W-1], num};
   assign mag      = num_x[ACC_W] ? $unsigned(-num_x) : $unsigned(num_x);
   // dividend 2|T|*2^TF + A over divisor 2A gives a rounded quotient
   assign dvd_init = (DIVD_W'(mag) << (TF + 1)) + DIVD_W'($unsigned(den));
   assign dvs_init = REM_W'($unsigned(den)) << 1;

   assign sh    = {rem_r[REM_W-2:0], quo_r[DIVD_W-1]};
   assign ge    = (sh >= dvs_r);
   assign rem_n = ge ? (sh - dvs_r) : sh;
   assign quo_n = {quo_r[DIVD_W-2:0], ge};

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_r <= 1'b0;
         cnt_r  <= '0;
         quo_r  <= '0;
         rem_r  <= '0;
         dvs_r  <= '0;
         neg_r  <= 1'b0;
      end else if (start && !busy_r) begin
         busy_r <= 1'b1;
         cnt_r  <= CNT_W'(DIVD_W);
         quo_r  <= dvd_init;
         rem_r  <= '0;
         dvs_r  <= dvs_init;
         neg_r  <= num[ACC_W-1];
      end else if (busy_r) begin
         quo_r <= quo_n;
         rem_r <= rem_n;
         cnt_r <= cnt_r - CNT_W'(1);
         if (cnt_r == CNT_W'(1)) busy_r <= 1'b0;
      end
   end

   assign busy = busy_r;
   assign fin  = busy_r && (cnt_r == CNT_W'(1));

   always_comb begin
      if (!neg_r)
         quo = (quo_n > POS_LIM) ? POS_LIM[OUT_W-1:0] : quo_n[OUT_W-1:0];
      else if (quo_n >= NEG_LIM)
         quo = {1'b1, {(OUT_W-1){1'b0}}};
      else
         quo = OUT_W'(0) - quo_n[OUT_W-1:0];
   end
endmodule

// File: rtl/ofe_estimator.sv
module ofe_estimator #(
   parameter int TAPS     = 5,
   parameter int SAMPLE_W = 12,
   parameter int COEF_W   = 16,
   parameter int ACC_W    = 32,
   parameter int OUT_W    = 16,
   parameter int TF       = 8,
   parameter int ADDR_W   = $clog2(2*TAPS + 1),
   parameter logic [TAPS*COEF_W-1:0] AMP_INIT  = ofe_pkg::AMP_Q15_DEF,
   parameter logic [TAPS*COEF_W-1:0] TIME_INIT = ofe_pkg::TIME_Q15_DEF
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic                     in_start,
   input  logic [SAMPLE_W-1:0]      in_sample,
   input  logic                     cfg_we,
   input  logic [ADDR_W-1:0]        cfg_addr,
   input  logic [COEF_W-1:0]        cfg_wdata,
   output logic                     busy,
   output logic                     amp_valid,
   output logic signed [OUT_W-1:0]  amp_out,
   output logic signed [OUT_W-1:0]  at_out,
   output logic                     time_valid,
   output logic                     time_bad,
   output logic signed [OUT_W-1:0]  time_out
);
   import ofe_pkg::*;

   localparam int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1;

   if (ACC_W < SAMPLE_W + COEF_W + 1 + $clog2(TAPS)) begin : g_chk_acc
      $error("ACC_W too narrow for the weighted sum");
   end
   if (SAMPLE_W > COEF_W) begin : g_chk_ped
      $error("pedestal must fit in the write data");
   end
   if (OUT_W > 31 || OUT_W < 2) begin : g_chk_out
      $error("OUT_W out of range");
   end
   if (ADDR_W < $clog2(2*TAPS + 1)) begin : g_chk_addr
      $error("ADDR_W cannot reach every register");
   end

   logic [TAPS*COEF_W-1:0] coef_flat [LANES];
   logic [SAMPLE_W-1:0]    ped;
   logic signed [ACC_W-1:0] sum_nxt [LANES];
   logic signed [OUT_W-1:0] rnd     [LANES];

   ofe_coef_bank #(
      .TAPS(TAPS), .COEF_W(COEF_W), .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W),
      .AMP_INIT(AMP_INIT), .TIME_INIT(TIME_INIT)
   ) u_bank (
      .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .amp_flat(coef_flat[LANE_AMP]), .time_flat(coef_flat[LANE_TIME]),
      .ped(ped)
   );

   // window sequencing
   logic             open_r, div_busy, div_fin, accept, take, last, div_go;
   logic [IDX_W-1:0] cnt_r, idx;
   logic signed [OUT_W-1:0] div_q;

   assign accept = in_valid && !div_busy;
   assign take   = accept && (in_start || open_r);
   assign idx    = in_start ? '0 : cnt_r;
   assign last   = take && (idx == IDX_W'(TAPS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         open_r <= 1'b0;
         cnt_r  <= '0;
      end else if (take) begin
         open_r <= !last;
         cnt_r  <= last ? '0 : idx + IDX_W'(1);
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      ofe_mac #(
         .TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W),
         .ACC_W(ACC_W), .OUT_W(OUT_W), .IDX_W(IDX_W)
      ) u_mac (
         .clk(clk), .rst(rst), .take(take), .first(in_start), .idx(idx),
         .sample(in_sample), .ped(ped), .coefs(coef_flat[l]),
         .sum_nxt(sum_nxt[l]), .rnd(rnd[l])
      );
   end

   assign div_go = last && (sum_nxt[LANE_AMP] > 0);

   ofe_divider #(.ACC_W(ACC_W), .TF(TF), .OUT_W(OUT_W)) u_div (
      .clk(clk), .rst(rst), .start(div_go),
      .num(sum_nxt[LANE_TIME]), .den(sum_nxt[LANE_AMP]),
      .busy(div_busy), .fin(div_fin), .quo(div_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         amp_valid  <= 1'b0;
         amp_out    <= '0;
         at_out     <= '0;
         time_valid <= 1'b0;
         time_bad   <= 1'b0;
         time_out   <= '0;
      end else begin
         amp_valid  <= 1'b0;
         time_valid <= 1'b0;
         time_bad   <= 1'b0;
         if (last) begin
            amp_valid <= 1'b1;
            amp_out   <= rnd[LANE_AMP];
            at_out    <= rnd[LANE_TIME];
            if (!(sum_nxt[LANE_AMP] > 0)) begin
               time_valid <= 1'b1;
               time_bad   <= 1'b1;
               time_out   <= '0;
            end
         end
         if (div_fin) begin
            time_valid <= 1'b1;
            time_out   <= div_q;
         end
      end
   end

   assign busy = div_busy;
endmodule

// File: rtl/ofe_estimator_chk.sv
module ofe_estimator_chk #(
   parameter int OUT_W   = 16,
   parameter int DIV_CYC = 42
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    busy,
   input logic                    amp_valid,
   input logic signed [OUT_W-1:0] amp_out,
   input logic                    time_valid,
   input logic                    time_bad,
   input logic signed [OUT_W-1:0] time_out
);
   localparam int CW = $clog2(DIV_CYC + 2);
   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst)       run_q <= '0;
      else if (busy) run_q <= run_q + CW'(1);
      else           run_q <= '0;
   end

   // R10
   busy_open_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> amp_valid);
   // R10
   busy_len_chk: assert property (@(posedge clk) disable iff (rst)
      busy |-> run_q < CW'(DIV_CYC));
   // R10
   busy_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (run_q == CW'(DIV_CYC)) && time_valid && !time_bad);
   // R10
   no_take_busy_chk: assert property (@(posedge clk) disable iff (rst)
      amp_valid |-> !$past(busy));
   // R9
   bad_time_chk: assert property (@(posedge clk) disable iff (rst)
      time_bad |-> time_valid && amp_valid && time_out == '0 && amp_out <= 0 && !busy);
   // R8
   good_time_chk: assert property (@(posedge clk) disable iff (rst)
      (time_valid && !time_bad) |-> $fell(busy));
endmodule

bind ofe_estimator ofe_estimator_chk #(.OUT_W(OUT_W), .DIV_CYC(ACC_W + TF + 2)) u_chk (
   .clk(clk), .rst(rst), .busy(busy), .amp_valid(amp_valid), .amp_out(amp_out),
   .time_valid(time_valid), .time_bad(time_bad), .time_out(time_out)
);

// File: tb/ofe_estimator_tb_top.sv
`timescale 1ns/1ps
module ofe_estimator_tb_top;
   typedef int win_t [5];

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0, in_start = 1'b0;
   logic [11:0] in_sample = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        busy, amp_valid, time_valid, time_bad;
   logic [15:0] amp_out, at_out, time_out;

   int n_chk = 0, n_err = 0;
   int ca [5] = '{5571, 11141, 13107, 10158, 9175};
   int ct [5] = '{-24576, 15401, 24576, 2294, -6226};
   int ped_m = 0;

   always #10 clk = ~clk;

   ofe_estimator dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
      .in_sample(in_sample), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .busy(busy), .amp_valid(amp_valid),
      .amp_out(amp_out), .at_out(at_out), .time_valid(time_valid),
      .time_bad(time_bad), .time_out(time_out)
   );

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   function automatic longint raw_sum(input bit tim, input win_t s);
      longint acc = 0;
      for (int i = 0; i < 5; i++)
         acc += longint'(s[i] - ped_m) * longint'(tim ? ct[i] : ca[i]);
      return acc;
   endfunction

   function automatic longint rnd_m(input longint x);
      longint y = (x + 16384) >>> 15;
      if (y > 32767) y = 32767;
      if (y < -32768) y = -32768;
      return y;
   endfunction

   function automatic longint quo_m(input longint t, input longint a);
      longint mag = (t < 0) ? -t : t;
      longint q = (2 * mag * 256 + a) / (2 * a);
      if (t < 0) return (q > 32768) ? -32768 : -q;
      return (q > 32767) ? 32767 : q;
   endfunction

   function automatic longint s16(input logic [15:0] v);
      return longint'($signed(v));
   endfunction

   task automatic wr(input int addr, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(val);
      @(negedge clk);
      cfg_we = 1'b0;
      if (addr < 5)       ca[addr]     = int'($signed(16'(val)));
      else if (addr < 10) ct[addr - 5] = int'($signed(16'(val)));
      else if (addr == 10) ped_m       = val & 4095;
   endtask

   // drives one window; checks sums, then the time path
   task automatic run_win(input win_t s, input int gap, input bit feed, input string rq);
      longint a, t;
      bit bad;
      a = raw_sum(1'b0, s);
      t = raw_sum(1'b1, s);
      bad = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_start = (i == 0); in_sample = 12'(s[i]);
         if (i < 4)
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               in_valid = 1'b0; in_start = 1'b0;
            end
      end
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0;
      chk(amp_valid == 1'b1, {rq, " amp_valid"}, longint'(amp_valid), 1);
      chk(s16(amp_out) == rnd_m(a), "R2 amp_out", s16(amp_out), rnd_m(a));
      chk(s16(at_out) == rnd_m(t), "R3 at_out", s16(at_out), rnd_m(t));
      if (a > 0) begin
         chk(busy && !time_valid, "R10 busy on", longint'(busy), 1);
         for (int k = 1; k < 42; k++) begin
            @(negedge clk);
            if (!busy || time_valid || amp_valid) bad = 1'b1;
            in_valid = feed; in_start = feed && (k == 1); in_sample = 12'd3000;
         end
         @(negedge clk);
         in_valid = 1'b0; in_start = 1'b0;
         chk(!bad, "R10 busy span", longint'(bad), 0);
         chk(time_valid && !time_bad && !busy, "R8 time_valid", longint'(time_valid), 1);
         chk(s16(time_out) == quo_m(t, a), {rq, " R8 time_out"}, s16(time_out), quo_m(t, a));
      end else begin
         chk(time_valid && time_bad && !busy && time_out == 16'd0, "R9 bad time",
             longint'(time_bad), 1);
         @(negedge clk);
         chk(!time_valid && !busy, "R9 single pulse", longint'(time_valid), 0);
      end
   endtask

   task automatic t_reset();
      chk(!amp_valid && !time_valid && !time_bad && !busy, "R1 flags", longint'(busy), 0);
      chk(amp_out == 0 && at_out == 0 && time_out == 0, "R1 data", s16(amp_out), 0);
   endtask

   task automatic t_reference();
      // R4 default weights, R2/R3/R8 on two pulse heights
      run_win('{0, 1260, 2000, 1600, 940}, 0, 1'b0, "R4");
      run_win('{300, 900, 1500, 1350, 700}, 0, 1'b0, "R2");
   endtask

   task automatic t_window();
      bit seen;
      seen = 1'b0;
      // R6: valid samples with no open window are ignored
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_start = 1'b0; in_sample = 12'(400 + i);
         if (amp_valid) seen = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (amp_valid) seen = 1'b1;
      chk(!seen, "R6 strays", longint'(seen), 0);
      run_win('{50, 700, 1200, 950, 500}, 2, 1'b0, "R6");
      // R7: restart after two samples
      @(negedge clk);
      in_valid = 1'b1; in_start = 1'b1; in_sample = 12'd4000;
      @(negedge clk);
      in_start = 1'b0; in_sample = 12'd4000;
      run_win('{10, 600, 1000, 800, 450}, 1, 1'b0, "R7");
   endtask

   task automatic t_busy_drop();
      bit seen;
      seen = 1'b0;
      run_win('{0, 1000, 1700, 1300, 800}, 0, 1'b1, "R10");
      // a start taken during busy would let these complete a window
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_start = 1'b0; in_sample = 12'd2000;
         if (amp_valid) seen = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (amp_valid) seen = 1'b1;
      chk(!seen, "R10 dropped start", longint'(seen), 0);
   endtask

   task automatic t_config();
      for (int i = 0; i < 5; i++) wr(i, (i == 0) ? 16384 : 0);
      for (int i = 5; i < 10; i++) wr(i, 0);
      wr(13, 12345);                       // R5 unmapped address
      run_win('{1, 0, 0, 0, 0}, 0, 1'b0, "R5");   // tie rounds up to 1
      wr(10, 1);
      run_win('{0, 0, 0, 0, 0}, 0, 1'b0, "R5");   // tie at -0.5 gives 0, R9
      wr(10, 2000);
      for (int i = 0; i < 5; i++) wr(i, 8000);
      run_win('{100, 200, 300, 150, 50}, 0, 1'b0, "R9");
      wr(10, 0);
      // R11 saturation both ways
      for (int i = 0; i < 5; i++) wr(i, (i == 2) ? 1 : 0);
      wr(5, 32767);
      run_win('{4000, 0, 100, 0, 0}, 0, 1'b0, "R11");
      wr(5, 32768);
      run_win('{4000, 0, 100, 0, 0}, 0, 1'b0, "R11");
      // restore reset weights
      wr(0, 5571); wr(1, 11141); wr(2, 13107); wr(3, 10158); wr(4, 9175);
      wr(5, -24576); wr(6, 15401); wr(7, 24576); wr(8, 2294); wr(9, -6226);
      run_win('{20, 800, 1300, 1000, 600}, 0, 1'b0, "R5");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_reference();
      t_window();
      t_busy_drop();
      t_config();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule